// File: doc/BRIEF.md
# Dual-Lane SIMD Accumulator ALU

This block is the add/compare unit of a fixed-point signal-processing datapath. It works on operands as wide as the accumulator, 40 bits. In full-width mode it adds, subtracts, or takes the signed maximum or minimum of two 40-bit operands. It raises a single overflow flag when a sum or difference does not fit in 40 signed bits. An optional saturation enable clamps the result to the signed 32-bit range.

In dual mode, the low 32 bits of each operand hold two packed signed 16-bit values. Each half is processed on its own, with no carry or borrow crossing between the halves. Each lane reports its own overflow flag, and saturation clamps each lane to the signed 16-bit range. The upper lane result is sign-extended into bits 39:16 of the output and the lower lane result fills bits 15:0. Inputs are sampled on each clock edge and the result appears on registered outputs one cycle later.

Top module: `simd_acc_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are all zero: `res_o`, `ovf_full_o` and `ovf_lane_o`.
- R2: With `mode_i`=0, `op_i`=0 (add) or 1 (subtract), and `sat_i`=0, the output one cycle later is a+b or a−b modulo 2^40.
- R3: With `mode_i`=0, `ovf_full_o` is 1 one cycle later exactly when an add or subtract result falls outside the signed 40-bit range. It is 0 for max and min, and 0 whenever `mode_i`=1.
- R4: With `mode_i`=0, `op_i`=2 gives the larger and `op_i`=3 gives the smaller of the two operands, each read as a signed 40-bit value.
- R5: With `mode_i`=0 and `sat_i`=1, any exact result above 2^31−1 is output as 2^31−1, and any exact result below −2^31 is output as −2^31, sign-extended to 40 bits. Results inside that range pass through unchanged.
- R6: With `mode_i`=1, lane 0 is bits 15:0 and lane 1 is bits 31:16 of each operand. Add and subtract are done per lane modulo 2^16, and no carry or borrow passes from lane 0 into lane 1.
- R7: With `mode_i`=1, `res_o[15:0]` is the lane 0 result and `res_o[31:16]` is the lane 1 result. Bits 39:32 all equal bit 31. Operand bits 39:32 have no effect on the output.
- R8: With `mode_i`=1, `ovf_lane_o[0]` and `ovf_lane_o[1]` flag signed 16-bit overflow of an add or subtract in lane 0 and lane 1. Both are 0 for max and min, and both are 0 whenever `mode_i`=0.
- R9: With `mode_i`=1, `op_i`=2 and 3 take the signed 16-bit maximum and minimum independently in each lane.
- R10: With `mode_i`=1 and `sat_i`=1, each lane's exact add or subtract result is clamped to the range −32768 to 32767. The lane's overflow flag still reports the overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 = full 40-bit, 1 = dual 16-bit lanes |
| op_i | input | 2 | 0 add, 1 subtract, 2 max, 3 min |
| sat_i | input | 1 | Saturation enable |
| a_i | input | 40 | First operand |
| b_i | input | 40 | Second operand |
| res_o | output | 40 | Registered result |
| ovf_full_o | output | 1 | Full-width overflow flag |
| ovf_lane_o | output | 2 | Per-lane overflow flags, bit 1 = upper lane |

## Verification
The cases hardest to reach from the ports are at the lane boundary. One lane must sit exactly at +32767, −32768 or −1 while the other lane carries or borrows, because only then would a leak across bit 16 or a misplaced clamp show in the result. The stimulus sweeps every combination of a boundary-heavy set of 16-bit values in both lanes of both operands, for all opcodes, with saturation on and off. The unused top byte holds a changing pattern throughout. The full-width path gets the same treatment with values at the 40-bit and 32-bit limits.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MAX = 2'd2,
    OP_MIN = 2'd3
  } alu_op_e;
endpackage

// File: rtl/simd_lane_op.sv
module simd_lane_op
  import simd_alu_pkg::*;
#(
  parameter int DW = 16,
  parameter int SW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_op_e       op,
  input  logic          sat_en,
  output logic [DW-1:0] y,
  output logic          ovf
);
  localparam int PADW = DW - SW + 2;
  localparam logic signed [DW:0] SAT_HI = {{PADW{1'b0}}, {(SW-1){1'b1}}};
  localparam logic signed [DW:0] SAT_LO = {{PADW{1'b1}}, {(SW-1){1'b0}}};

  logic signed [DW:0] ax, bx, ex;
  logic               arith;

  always_comb begin
    ax    = {a[DW-1], a};
    bx    = {b[DW-1], b};
    arith = (op == OP_ADD) || (op == OP_SUB);
    case (op)
      OP_ADD:  ex = ax + bx;
      OP_SUB:  ex = ax - bx;
      OP_MAX:  ex = (ax > bx) ? ax : bx;
      default: ex = (ax < bx) ? ax : bx;
    endcase
    ovf = arith && (ex[DW] != ex[DW-1]);
    if (sat_en && (ex > SAT_HI))      y = SAT_HI[DW-1:0];
    else if (sat_en && (ex < SAT_LO)) y = SAT_LO[DW-1:0];
    else                              y = ex[DW-1:0];
  end

  // R4 R9: a max/min result is one of the operands and bounds both
  always_comb begin
    if (!sat_en && (op == OP_MAX)) begin
      p_max_bound_r9: assert (($signed(y) >= $signed(a)) && ($signed(y) >= $signed(b)) && (y == a || y == b));
    end
    if (!sat_en && (op == OP_MIN)) begin
      p_min_bound_r9: assert (($signed(y) <= $signed(a)) && ($signed(y) <= $signed(b)) && (y == a || y == b));
    end
  end
endmodule

// File: rtl/simd_acc_alu.sv
module simd_acc_alu
  import simd_alu_pkg::*;
#(
  parameter int W  = 40,
  parameter int LW = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_i,
  input  logic [1:0]   op_i,
  input  logic         sat_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         ovf_full_o,
  output logic [1:0]   ovf_lane_o
);
  localparam int NL   = 2;
  localparam int PACK = NL * LW;
  localparam int EXTW = W - PACK;

  alu_op_e        op;
  logic [W-1:0]   full_y;
  logic           full_ovf;
  logic [LW-1:0]  lane_y   [NL];
  logic [NL-1:0]  lane_ovf;
  logic [W-1:0]   dual_y;

  assign op = alu_op_e'(op_i);

  simd_lane_op #(.DW(W), .SW(PACK)) u_full (
    .a(a_i), .b(b_i), .op(op), .sat_en(sat_i), .y(full_y), .ovf(full_ovf)
  );

  for (genvar g = 0; g < NL; g++) begin : g_lane
    simd_lane_op #(.DW(LW), .SW(LW)) u_lane (
      .a(a_i[g*LW +: LW]), .b(b_i[g*LW +: LW]), .op(op), .sat_en(sat_i),
      .y(lane_y[g]), .ovf(lane_ovf[g])
    );
  end

  assign dual_y = {{EXTW{lane_y[NL-1][LW-1]}}, lane_y[1], lane_y[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o      <= '0;
      ovf_full_o <= 1'b0;
      ovf_lane_o <= '0;
    end else begin
      res_o      <= mode_i ? dual_y : full_y;
      ovf_full_o <= !mode_i && full_ovf;
      ovf_lane_o <= mode_i ? lane_ovf : '0;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (res_o == '0) && !ovf_full_o && (ovf_lane_o == '0));

  p_dual_no_full_flag_r3: assert property (@(posedge clk) disable iff (rst)
    mode_i |=> !ovf_full_o);

  p_full_no_lane_flag_r8: assert property (@(posedge clk) disable iff (rst)
    !mode_i |=> (ovf_lane_o == '0));

  p_dual_sign_ext_r7: assert property (@(posedge clk) disable iff (rst)
    mode_i |=> (res_o[W-1:PACK-1] == {(EXTW+1){res_o[PACK-1]}}));

  p_full_sat_range_r5: assert property (@(posedge clk) disable iff (rst)
    (!mode_i && sat_i) |=> (res_o[W-1:PACK-1] == {(EXTW+1){res_o[W-1]}}));
endmodule

// File: tb/sim_simd_acc_alu.sv
module sim_simd_acc_alu;
  logic        clk = 1'b0;
  logic        rst;
  logic        mode_i;
  logic [1:0]  op_i;
  logic        sat_i;
  logic [39:0] a_i, b_i;
  logic [39:0] res_o;
  logic        ovf_full_o;
  logic [1:0]  ovf_lane_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  simd_acc_alu u0 (
    .clk(clk), .rst(rst), .mode_i(mode_i), .op_i(op_i), .sat_i(sat_i),
    .a_i(a_i), .b_i(b_i), .res_o(res_o), .ovf_full_o(ovf_full_o),
    .ovf_lane_o(ovf_lane_o)
  );

  function automatic logic [15:0] lval(int i);
    case (i)
      0: return 16'h0000;  1: return 16'h0001;
      2: return 16'hFFFF;  3: return 16'h7FFF;
      4: return 16'h8000;  5: return 16'h7FFE;
      6: return 16'h8001;  default: return 16'h1234;
    endcase
  endfunction

  function automatic logic [39:0] fval(int i);
    case (i)
      0: return 40'h00_0000_0000;  1: return 40'h00_0000_0001;
      2: return 40'hFF_FFFF_FFFF;  3: return 40'h7F_FFFF_FFFF;
      4: return 40'h80_0000_0000;  5: return 40'h00_7FFF_FFFF;
      6: return 40'hFF_8000_0000;  7: return 40'h00_8000_0000;
      default: return 40'hC3_1234_5678;
    endcase
  endfunction

  function automatic longint calc(int op, longint x, longint y);
    case (op)
      0: return x + y;
      1: return x - y;
      2: return (x > y) ? x : y;
      default: return (x < y) ? x : y;
    endcase
  endfunction

  task automatic compare(string tag, logic [39:0] er, logic ef, logic [1:0] el);
    compared++;
    if (res_o !== er || ovf_full_o !== ef || ovf_lane_o !== el) begin
      mismatched++;
      $display("FAIL %s: res=%h full=%b lane=%b expected res=%h full=%b lane=%b",
               tag, res_o, ovf_full_o, ovf_lane_o, er, ef, el);
    end
  endtask

  task automatic apply(logic m, int op, logic s, logic [39:0] a, logic [39:0] b);
    @(negedge clk);
    mode_i = m; op_i = op[1:0]; sat_i = s; a_i = a; b_i = b;
    @(posedge clk);
    #1;
  endtask

  task automatic run_full(int op, logic s, logic [39:0] a, logic [39:0] b);
    longint x, y, e;
    logic [63:0] t;
    logic ef;
    string tag;
    x = longint'({{24{a[39]}}, a});
    y = longint'({{24{b[39]}}, b});
    e = calc(op, x, y);
    ef = (op < 2) && (e > 64'sh7F_FFFF_FFFF || e < -64'sh80_0000_0000);
    if (s && e > 64'sh7FFF_FFFF) e = 64'sh7FFF_FFFF;
    if (s && e < -64'sh8000_0000) e = -64'sh8000_0000;
    t = e;
    if (s) tag = "R5 R3";
    else if (op >= 2) tag = "R4 R3";
    else tag = "R2 R3";
    apply(1'b0, op, s, a, b);
    compare(tag, t[39:0], ef, 2'b00);
  endtask

  task automatic lane_model(int op, logic s, logic [15:0] a, logic [15:0] b,
                            output logic [15:0] r, output logic f);
    longint e;
    logic [63:0] t;
    e = calc(op, longint'($signed(a)), longint'($signed(b)));
    f = (op < 2) && (e > 32767 || e < -32768);
    if (s && e > 32767) e = 32767;
    if (s && e < -32768) e = -32768;
    t = e;
    r = t[15:0];
  endtask

  task automatic run_dual(int op, logic s, logic [39:0] a, logic [39:0] b);
    logic [15:0] rh, rl;
    logic fh, fl;
    string tag;
    lane_model(op, s, a[31:16], b[31:16], rh, fh);
    lane_model(op, s, a[15:0], b[15:0], rl, fl);
    if (op >= 2) tag = "R9 R7 R8";
    else if (s) tag = "R10 R7 R8";
    else tag = "R6 R7 R8";
    apply(1'b1, op, s, a, b);
    compare(tag, {{8{rh[15]}}, rh, rl}, 1'b0, {fh, fl});
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int k;
    rst = 1'b1; mode_i = 1'b1; op_i = 2'd0; sat_i = 1'b1;
    a_i = 40'hFF_FFFF_FFFF; b_i = 40'hFF_FFFF_FFFF;
    @(posedge clk); #1;
    compare("R1 reset", 40'h0, 1'b0, 2'b00);
    @(negedge clk); rst = 1'b0;

    for (int op = 0; op < 4; op++)
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < 9; i++)
          for (int j = 0; j < 9; j++)
            run_full(op, s[0], fval(i), fval(j));

    k = 0;
    for (int op = 0; op < 4; op++)
      for (int s = 0; s < 2; s++)
        for (int ah = 0; ah < 8; ah++)
          for (int al = 0; al < 8; al++)
            for (int bh = 0; bh < 8; bh++)
              for (int bl = 0; bl < 8; bl++) begin
                k++;
                run_dual(op, s[0], {k[7:0], lval(ah), lval(al)},
                         {~k[7:0], lval(bh), lval(bl)});
              end

    // R1: reset mid-run clears an active result
    apply(1'b0, 0, 1'b0, 40'h7F_FFFF_FFFF, 40'h1);
    compare("R2 R3", 40'h80_0000_0000, 1'b1, 2'b00);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    compare("R1 midrun", 40'h0, 1'b0, 2'b00);
    @(negedge clk); rst = 1'b0;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule